// File: doc/BRIEF.md
# Repeating Memory Block Copy Engine

This engine moves a run of bytes from one region of a byte-wide memory to another, one byte per iteration, the way a repeating block-move instruction does inside an 8-bit processor core. A one-cycle `start` pulse loads three 16-bit registers: a source pointer, a destination pointer and a byte count. It also loads a direction select and an 8-bit flag byte. The engine then repeats read-then-write iterations until the count runs out.

Every iteration follows a fixed machine-cycle schedule measured in clock states (one clock each). Two 4-state fetch-shaped cycles (FETCH1, FETCH2) come first. A 3-state READ cycle then reads the source byte. A 5-state WRITE cycle stores that byte and steps the registers. A 5-state INTERNAL cycle with no bus activity follows only when bytes remain. The engine measures the length of each iteration and reports it, so an enclosing core can account for time. It updates the half-carry, subtract and parity/overflow flags and passes the other flag bits through unchanged.

Sequencer states: IDLE, FETCH1, FETCH2, READ, WRITE, INTERNAL. Transitions:
- IDLE→FETCH1 on `start`.
- FETCH1→FETCH2, FETCH2→READ and READ→WRITE on the last state of each cycle.
- WRITE→INTERNAL on its last state when the decremented count is non-zero.
- WRITE→IDLE on its last state when the decremented count is zero.
- INTERNAL→FETCH1 on its last state.

Top module: `blkcopy_engine`

## Requirements
- R1: A `start` pulse while `busy` is low loads `src_in`, `dst_in`, `cnt_in`, `dir_down` and `flags_in`, and `busy` is high from the next cycle. A `start` pulse while `busy` is high is ignored: the results of the run in progress are unchanged.
- R2: Counting the first busy cycle of an iteration as state 1, `mem_rd` is high for exactly state 9 (first state of READ) with `mem_addr` equal to the source pointer. The memory returns `mem_rdata` one clock later. `mem_wr` is high for exactly state 12 (first state of WRITE) with `mem_addr` equal to the destination pointer and `mem_wdata` equal to the byte read.
- R3: After each transfer both pointers step by +1 when `dir_down` was 0 at start, or by -1 when it was 1, modulo 2^16. In both directions the byte count steps by -1.
- R4: Iterations repeat until the count reaches zero. The final memory equals a sequential byte-by-byte copy in the chosen direction, overlapping regions included.
- R5: An iteration that leaves the count non-zero lasts 21 clocks (4+4+3+5+5). `iter_done` pulses for one cycle right after it, with `iter_len` = 21.
- R6: The iteration that leaves the count at zero lasts 16 clocks (4+4+3+5). It is followed by an `iter_done` pulse with `iter_len` = 16.
- R7: Every iteration clears flag bit 4 (half-carry) and flag bit 1 (subtract).
- R8: After each iteration flag bit 2 (parity/overflow) is 1 when the decremented count is non-zero and 0 when it is zero.
- R9: Flag bits 7 (sign), 6 (zero) and 0 (carry), and bits 5 and 3, keep the values loaded from `flags_in`.
- R10: `done` pulses for one cycle in the same cycle as the final `iter_done`, and `busy` is low in that cycle.
- R11: A start count of zero means 65536 transfers. The first iteration leaves the count at 16'hFFFF with flag bit 2 set and lasts 21 clocks.
- R12: While `rst_n` is low the engine returns to IDLE with `busy`, `done`, `iter_done`, the pointers, the count and the flags all at zero. This also aborts a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load registers and begin a copy |
| dir_down | input | 1 | 0 = ascending addresses, 1 = descending |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte count (0 means 65536) |
| flags_in | input | 8 | Flag byte loaded at start |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse after the final iteration |
| iter_done | output | 1 | One-cycle pulse after each iteration |
| iter_len | output | 5 | Clock states used by the last iteration |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| byte_cnt | output | 16 | Current byte count |
| flags | output | 8 | Current flag byte |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_rd` |

## Verification
Random copies with counts of 1 to 10, random pointers, random direction and random incoming flags are checked against a bench reference copy. Overlapping source and destination regions, copied ascending and descending, separate a true byte-sequential copy from one that buffers or reorders. A single-byte copy isolates the 16-clock final iteration. A zero start count, observed for one iteration and then aborted by reset, shows the wrap to 65536. A stray `start` during a run shows that the loaded values stay protected.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH1,
        S_FETCH2,
        S_READ,
        S_WRITE,
        S_INTERNAL
    } mc_state_e;

    localparam int unsigned FETCH_STATES    = 4;
    localparam int unsigned READ_STATES     = 3;
    localparam int unsigned WRITE_STATES    = 5;
    localparam int unsigned INTERNAL_STATES = 5;

    localparam int unsigned SHORT_ITER = 2 * FETCH_STATES + READ_STATES + WRITE_STATES;
    localparam int unsigned LONG_ITER  = SHORT_ITER + INTERNAL_STATES;

    localparam int unsigned FLG_SIGN = 7;
    localparam int unsigned FLG_ZERO = 6;
    localparam int unsigned FLG_HALF = 4;
    localparam int unsigned FLG_PV   = 2;
    localparam int unsigned FLG_SUB  = 1;
    localparam int unsigned FLG_CARRY = 0;

    function automatic int unsigned mc_len(mc_state_e s);
        int unsigned n;
        unique case (s)
            S_FETCH1, S_FETCH2: n = FETCH_STATES;
            S_READ:             n = READ_STATES;
            S_WRITE:            n = WRITE_STATES;
            S_INTERNAL:         n = INTERNAL_STATES;
            default:            n = 1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
    import blkcopy_pkg::*;
#(
    parameter int unsigned TW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic more,
    output logic busy,
    output logic load,
    output logic rd_en,
    output logic capture,
    output logic wr_en,
    output logic step,
    output logic iter_end,
    output logic last_iter
);

    mc_state_e     state, nxt;
    logic [TW-1:0] tcnt;
    logic          last_t;

    assign last_t = (tcnt == TW'(mc_len(state) - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            tcnt  <= '0;
        end else begin
            state <= nxt;
            tcnt  <= (state == S_IDLE || last_t) ? '0 : tcnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start)  nxt = S_FETCH1;
            S_FETCH1:   if (last_t) nxt = S_FETCH2;
            S_FETCH2:   if (last_t) nxt = S_READ;
            S_READ:     if (last_t) nxt = S_WRITE;
            S_WRITE:    if (last_t) nxt = more ? S_INTERNAL : S_IDLE;
            S_INTERNAL: if (last_t) nxt = S_FETCH1;
            default:    nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        load      = 1'b0;
        rd_en     = 1'b0;
        capture   = 1'b0;
        wr_en     = 1'b0;
        step      = 1'b0;
        iter_end  = 1'b0;
        last_iter = 1'b0;
        unique case (state)
            S_IDLE:     load = start;
            S_READ: begin
                rd_en   = (tcnt == '0);
                capture = (tcnt == TW'(1));
            end
            S_WRITE: begin
                wr_en     = (tcnt == '0);
                step      = last_t;
                iter_end  = last_t && !more;
                last_iter = last_t && !more;
            end
            S_INTERNAL: iter_end = last_t;
            default: ;
        endcase
    end

endmodule

// File: rtl/blkcopy_regs.sv
module blkcopy_regs
    import blkcopy_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 8,
    parameter int unsigned FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dir_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [FW-1:0] flags_in,
    input  logic          capture,
    input  logic [DW-1:0] rdata,
    input  logic          step,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] byte_cnt,
    output logic [FW-1:0] flags,
    output logic [DW-1:0] data_q,
    output logic          more
);

    logic          dir_q;
    logic [CW-1:0] cnt_dec;
    logic [AW-1:0] delta;

    assign cnt_dec = byte_cnt - 1'b1;
    assign more    = |cnt_dec;
    assign delta   = dir_q ? {AW{1'b1}} : AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr  <= '0;
            dst_ptr  <= '0;
            byte_cnt <= '0;
            flags    <= '0;
            data_q   <= '0;
            dir_q    <= 1'b0;
        end else begin
            if (load) begin
                src_ptr  <= src_in;
                dst_ptr  <= dst_in;
                byte_cnt <= cnt_in;
                flags    <= flags_in;
                dir_q    <= dir_in;
            end
            if (capture) begin
                data_q <= rdata;
            end
            if (step) begin
                src_ptr          <= src_ptr + delta;
                dst_ptr          <= dst_ptr + delta;
                byte_cnt         <= cnt_dec;
                flags[FLG_HALF]  <= 1'b0;
                flags[FLG_SUB]   <= 1'b0;
                flags[FLG_PV]    <= more;
            end
        end
    end

endmodule

// File: rtl/blkcopy_timer.sv
module blkcopy_timer #(
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          busy,
    input  logic          iter_end,
    input  logic          last_iter,
    output logic          iter_done,
    output logic          done,
    output logic [IW-1:0] iter_len
);

    logic [IW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            iter_len  <= '0;
            iter_done <= 1'b0;
            done      <= 1'b0;
        end else begin
            iter_done <= iter_end;
            done      <= last_iter;
            if (load) begin
                run_cnt <= '0;
            end else if (iter_end) begin
                iter_len <= run_cnt + 1'b1;
                run_cnt  <= '0;
            end else if (busy) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 8,
    parameter int unsigned FW = 8,
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_down,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [FW-1:0] flags_in,
    output logic          busy,
    output logic          done,
    output logic          iter_done,
    output logic [IW-1:0] iter_len,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] byte_cnt,
    output logic [FW-1:0] flags,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int unsigned MAXMC = (WRITE_STATES > INTERNAL_STATES) ? WRITE_STATES : INTERNAL_STATES;
    localparam int unsigned TW    = $clog2(MAXMC);

    logic load, capture, step, iter_end, last_iter, more;

    blkcopy_seq #(.TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .more      (more),
        .busy      (busy),
        .load      (load),
        .rd_en     (mem_rd),
        .capture   (capture),
        .wr_en     (mem_wr),
        .step      (step),
        .iter_end  (iter_end),
        .last_iter (last_iter)
    );

    blkcopy_regs #(.AW(AW), .CW(CW), .DW(DW), .FW(FW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .dir_in   (dir_down),
        .src_in   (src_in),
        .dst_in   (dst_in),
        .cnt_in   (cnt_in),
        .flags_in (flags_in),
        .capture  (capture),
        .rdata    (mem_rdata),
        .step     (step),
        .src_ptr  (src_ptr),
        .dst_ptr  (dst_ptr),
        .byte_cnt (byte_cnt),
        .flags    (flags),
        .data_q   (mem_wdata),
        .more     (more)
    );

    blkcopy_timer #(.IW(IW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .busy      (busy),
        .iter_end  (iter_end),
        .last_iter (last_iter),
        .iter_done (iter_done),
        .done      (done),
        .iter_len  (iter_len)
    );

    assign mem_addr = mem_rd ? src_ptr : dst_ptr;

endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk
    import blkcopy_pkg::*;
#(
    parameter int unsigned CW = 16,
    parameter int unsigned FW = 8,
    parameter int unsigned IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          iter_done,
    input logic [IW-1:0] iter_len,
    input logic [CW-1:0] byte_cnt,
    input logic [FW-1:0] flags,
    input logic          mem_rd,
    input logic          mem_wr
);

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (byte_cnt == $past(byte_cnt) || byte_cnt == $past(byte_cnt) - 1'b1));

    p_long_iter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_done && flags[FLG_PV]) |-> (iter_len == IW'(LONG_ITER)));

    p_short_iter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_done && !flags[FLG_PV]) |-> (iter_len == IW'(SHORT_ITER)));

    p_hn_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iter_done |-> (!flags[FLG_HALF] && !flags[FLG_SUB]));

    p_szc_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (flags[FLG_SIGN] == $past(flags[FLG_SIGN]) &&
                                   flags[FLG_ZERO] == $past(flags[FLG_ZERO]) &&
                                   flags[FLG_CARRY] == $past(flags[FLG_CARRY])));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && iter_done && byte_cnt == '0));

endmodule

bind blkcopy_engine blkcopy_chk #(.CW(CW), .FW(FW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .iter_done (iter_done),
    .iter_len  (iter_len),
    .byte_cnt  (byte_cnt),
    .flags     (flags),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/blkcopy_engine_test.sv
`timescale 1ns/1ps
module blkcopy_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_down = 1'b0;
    logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
    logic [7:0]  flags_in = '0;
    logic        busy, done, iter_done;
    logic [4:0]  iter_len;
    logic [15:0] src_ptr, dst_ptr, byte_cnt, mem_addr;
    logic [7:0]  flags, mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rd, mem_wr;

    logic [7:0]  mem [256];
    logic [7:0]  refm [256];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    blkcopy_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .flags_in(flags_in),
        .busy(busy), .done(done), .iter_done(iter_done), .iter_len(iter_len),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .byte_cnt(byte_cnt), .flags(flags),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // synchronous byte memory, one clock read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step_ptr(input logic [15:0] p, input logic down, input int k);
        return down ? p - 16'(k) : p + 16'(k);
    endfunction

    function automatic logic [7:0] exp_flags(input logic [7:0] f, input bit pv);
        logic [7:0] r = f;
        r[4] = 1'b0;
        r[1] = 1'b0;
        r[2] = pv;
        return r;
    endfunction

    task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input int n,
                            input logic down, input logic [7:0] fl, input bit poke);
        int c, last_c, it, rd_n, wr_n, bus_bad, len_bad, pv_bad, mem_bad;
        logic [15:0] ss, dd;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'($urandom);
            refm[i] = mem[i];
        end
        ss = s; dd = d;
        for (int i = 0; i < n; i++) begin
            refm[dd[7:0]] = refm[ss[7:0]];
            ss = step_ptr(ss, down, 1);
            dd = step_ptr(dd, down, 1);
        end
        @(negedge clk);
        start = 1'b1; src_in = s; dst_in = d; cnt_in = 16'(n); dir_down = down; flags_in = fl;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R1 busy after start", busy, 1);
        c = 1; last_c = 1; it = 0; rd_n = 0; wr_n = 0;
        bus_bad = 0; len_bad = 0; pv_bad = 0;
        while (c < 5000) begin
            int pos, k;
            pos = (c - 1) % 21 + 1;
            k   = (c - 1) / 21;
            if (poke && c == 3) begin
                start = 1'b1; src_in = ~s; dst_in = ~d; cnt_in = 16'd99;
                dir_down = ~down; flags_in = ~fl;
            end
            if (poke && c == 4) start = 1'b0;
            if (mem_rd) begin
                rd_n++;
                if (pos != 9 || mem_addr !== step_ptr(s, down, k)) bus_bad++;
            end
            if (mem_wr) begin
                wr_n++;
                if (pos != 12 || mem_addr !== step_ptr(d, down, k)) bus_bad++;
            end
            if (iter_done) begin
                int gap = c - last_c;
                bit fin = (it == n - 1);
                if (fin) check(gap == 16 && iter_len == 5'd16, "R6 final iteration length", iter_len, 16);
                else if (gap != 21 || iter_len != 5'd21) len_bad++;
                if (flags[2] !== !fin) pv_bad++;
                last_c = c;
                it++;
                if (fin) begin
                    check(done === 1'b1 && busy === 1'b0, "R10 done with final iter_done", {done, busy}, 2'b10);
                    break;
                end
            end
            if (done) break;
            @(negedge clk);
            c++;
        end
        check(it == n, "R4 iteration count", it, n);
        check(len_bad == 0, "R5 long iteration length", len_bad, 0);
        check(pv_bad == 0, "R8 parity/overflow per iteration", pv_bad, 0);
        check(bus_bad == 0 && rd_n == n && wr_n == n, "R2 bus timing", bus_bad, 0);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R10 done is one pulse", done, 0);
        mem_bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) mem_bad++;
        check(mem_bad == 0, "R4 memory contents", mem_bad, 0);
        check(src_ptr === ss && dst_ptr === dd, "R3 final pointers", {src_ptr, dst_ptr}, {ss, dd});
        check(byte_cnt === 16'd0, "R3 final count", byte_cnt, 0);
        check(flags[4] === 1'b0 && flags[1] === 1'b0, "R7 half-carry and subtract cleared", flags, exp_flags(fl, 0));
        check(flags === exp_flags(fl, 0), "R9 other flag bits kept", flags, exp_flags(fl, 0));
        if (poke) check(src_ptr === ss && flags === exp_flags(fl, 0), "R1 start ignored while busy", src_ptr, ss);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && byte_cnt === 16'd0 && flags === 8'd0 && done === 1'b0, "R12 reset state", busy, 0);
        rst_n = 1'b1;

        // directed corners
        run_copy(16'h0040, 16'h0080, 1, 1'b0, 8'hFF, 1'b0);   // single byte, all flags set
        run_copy(16'h0010, 16'h0012, 6, 1'b0, 8'hC1, 1'b0);   // overlap ascending
        run_copy(16'h0025, 16'h0027, 6, 1'b1, 8'h29, 1'b0);   // overlap descending
        run_copy(16'h0001, 16'hFFFE, 4, 1'b1, 8'h16, 1'b0);   // pointer wrap below zero
        run_copy(16'h0030, 16'h0090, 5, 1'b0, 8'h55, 1'b1);   // stray start during run

        // constrained random
        for (int r = 0; r < 14; r++) begin
            run_copy(16'($urandom), 16'($urandom), int'($urandom_range(1, 10)),
                     1'($urandom), 8'($urandom), 1'b0);
        end

        // zero count: observe first iteration, then abort with reset
        @(negedge clk);
        start = 1'b1; src_in = 16'h0010; dst_in = 16'h0080; cnt_in = 16'd0;
        dir_down = 1'b0; flags_in = 8'h00;
        @(negedge clk);
        start = 1'b0;
        repeat (30) begin
            if (iter_done) break;
            @(negedge clk);
        end
        check(iter_done === 1'b1 && iter_len === 5'd21, "R11 zero count first iteration length", iter_len, 21);
        check(byte_cnt === 16'hFFFF && flags[2] === 1'b1 && busy === 1'b1, "R11 zero count wraps", byte_cnt, 16'hFFFF);
        check(src_ptr === 16'h0011 && dst_ptr === 16'h0081, "R11 pointers after first", src_ptr, 16'h0011);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy === 1'b0 && byte_cnt === 16'd0 && src_ptr === 16'd0 && flags === 8'd0,
              "R12 reset aborts run", byte_cnt, 0);
        rst_n = 1'b1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule